// File: doc/BRIEF.md
# Framed Sample Capture Packer

This block turns a stream of qualified samples into framed records. Two strobe inputs frame each record: one opens it and one closes it. A per-strobe configuration bit selects whether the rising or the falling transition of that strobe is the active event. Samples are 8, 16 or 32 bits wide. They are packed little-endian into 32-bit words and handed to a downstream memory writer through a valid/ready word port. A small internal word queue absorbs short stalls.

A programmed record length limits how many samples a record may keep. Samples beyond that limit are discarded, and an enabled overflow interrupt pulses once for the record. Header mode adds two words to each record: a timestamp word ahead of the data, and a word after the data that holds the number of samples stored. Each completed record produces a done pulse. Each time a programmed number of records has completed, a buffer-switch pulse tells the address logic to move to its next buffer.

Top module: `msg_packer`

## Requirements
- R1: After synchronous reset, o_valid, irq_overflow, msg_done, buf_switch and drop_err are all 0.
- R2: A sample is captured only on a clock edge where s_valid is 1. Edges with s_valid 0 add nothing to the record.
- R3: A record opens on the start event. The event is a 0-to-1 change of start_pin when cfg_start_fall=0, and a 1-to-0 change when cfg_start_fall=1, comparing the value sampled at this edge with the value sampled at the previous edge. A valid sample on the opening edge is the first sample. A start event while a record is open is ignored.
- R4: A record closes on the stop event, with the edge selected by cfg_stop_fall in the same way. A valid sample on the closing edge is the last sample. A stop event while no record is open has no effect.
- R5: cfg_width selects the sample width: 0 is 8-bit, 1 is 16-bit, 2 and 3 are 32-bit. Only the low bits of s_data are used. Samples fill each word starting at byte 0, in arrival order.
- R6: A record of B data bytes produces ceil(B/4) data words. The unused upper bytes of the final word are zero.
- R7: A record keeps at most cfg_rec_size samples and later samples are dropped. A cfg_rec_size of 0 or 1 acts as 2.
- R8: When cfg_ovf_ie=1, a record that drops samples produces exactly one single-cycle irq_overflow pulse. When cfg_ovf_ie=0, it produces none.
- R9: With cfg_hdr_en=1, each record is preceded by a timestamp word and followed by a length word. The timestamp is a free-running cycle counter value taken at the opening edge, so the difference between two timestamps equals the number of cycles between the two start events. The length word is the number of samples stored.
- R10: msg_done pulses for one cycle after every closing edge. buf_switch pulses together with msg_done on every cfg_buf_size-th record after reset (a value of 0 acts as 1).
- R11: A word leaves on each edge where o_valid and o_ready are both 1. While o_ready is 0, o_data holds steady. Word order is kept.
- R12: Words that do not fit in the full queue are discarded, and drop_err sets and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Sample qualifier |
| s_data | input | 32 | Sample value, low bits used for narrow widths |
| start_pin | input | 1 | Record-open strobe |
| stop_pin | input | 1 | Record-close strobe |
| cfg_start_fall | input | 1 | 1: falling edge of start_pin is active |
| cfg_stop_fall | input | 1 | 1: falling edge of stop_pin is active |
| cfg_width | input | 2 | Sample width code |
| cfg_rec_size | input | CNT_W | Record length limit in samples |
| cfg_buf_size | input | CNT_W | Records per buffer |
| cfg_hdr_en | input | 1 | Insert timestamp and length words |
| cfg_ovf_ie | input | 1 | Overflow interrupt enable |
| o_valid | output | 1 | Output word available |
| o_ready | input | 1 | Downstream accepts word |
| o_data | output | 32 | Output word |
| irq_overflow | output | 1 | Truncation interrupt pulse |
| msg_done | output | 1 | Record completed pulse |
| buf_switch | output | 1 | Buffer switch pulse |
| drop_err | output | 1 | Sticky queue-overflow flag |

## Verification
A word completed at an edge enters the queue at that edge and shows on o_data, with o_valid set, from that edge on. The done, switch and overflow pulses are registered, so each rises on the edge that follows the edge where the stop event or the first dropped sample occurs. The bench therefore collects outputs with a monitor that samples on each rising edge, as a downstream flop would. It compares a record only after a settling window of twelve idle cycles, which is longer than any path from the last sample to the last output word. Stimulus changes only on falling edges, so no comparison depends on the order of processes at an edge.

// File: rtl/msg_packer_pkg.sv
// Shared constants and helpers for the framed sample packer.
// Assumes: output words are 32 bits wide, and at most three words are produced per cycle.
package msg_packer_pkg;
    localparam int WORD_W   = 32;
    localparam int MAX_PUSH = 3;

    typedef enum logic [1:0] {
        SW_BYTE  = 2'b00,
        SW_HALF  = 2'b01,
        SW_WORD  = 2'b10,
        SW_WORD2 = 2'b11
    } samp_w_e;

    // Bytes per sample for a width code
    function automatic logic [2:0] samp_bytes(input logic [1:0] code);
        case (samp_w_e'(code))
            SW_BYTE: return 3'd1;
            SW_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/msg_edge_det.sv
// Strobe event detector: compares the pin value at this edge with the value
// held from the previous edge and flags the selected transition.
// Assumes the pin is already synchronous to clk.
module msg_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic evt
);
    logic prev;

    // Hold the pin value from the last edge
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= pin;
    end

    // Select the rising or falling transition
    always_comb evt = fall_sel ? (prev & ~pin) : (~prev & pin);
endmodule

// File: rtl/msg_word_fifo.sv
// Word queue that accepts up to NPUSH words per cycle and releases one per
// cycle over valid/ready. Words that find no room are discarded and set a
// sticky error. Assumes DEPTH is a power of two and greater than NPUSH.
module msg_word_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    parameter int NPUSH = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              push_n,
    input  logic [NPUSH-1:0][W-1:0] push_dat,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [W-1:0]            out_data,
    output logic                    drop_err
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_idx, rd_idx;
    logic [CW-1:0] count, free_n, req_n, acc_n;
    logic          pop;

    // Admission: accept as many words as there is room for
    always_comb begin
        pop    = out_valid & out_ready;
        free_n = CW'(DEPTH) - count;
        req_n  = CW'(push_n);
        acc_n  = (req_n > free_n) ? free_n : req_n;
    end

    // Storage write, slots in order from the write index
    always_ff @(posedge clk) begin
        for (int k = 0; k < NPUSH; k++)
            if (CW'(k) < acc_n) mem[wr_idx + AW'(k)] <= push_dat[k];
    end

    // Pointer, fill level and sticky drop flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx   <= '0;
            rd_idx   <= '0;
            count    <= '0;
            drop_err <= 1'b0;
        end else begin
            wr_idx   <= wr_idx + acc_n[AW-1:0];
            rd_idx   <= rd_idx + AW'(pop);
            count    <= count + acc_n - CW'(pop);
            drop_err <= drop_err | (req_n > free_n);
        end
    end

    // Head of queue drives the output
    always_comb begin
        out_valid = (count != '0);
        out_data  = mem[rd_idx];
    end

    a_r12_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        drop_err |=> drop_err);
    a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    a_r12_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/msg_framer.sv
// Record framer: tracks the open record, packs qualified samples into words,
// truncates at the record limit, and emits header words and completion
// pulses. Produces up to three words per cycle, in order, in slots 0..n-1.
// Assumes configuration is stable while a record is open.
module msg_framer
    import msg_packer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          s_valid,
    input  logic [WORD_W-1:0]             s_data,
    input  logic                          evt_start,
    input  logic                          evt_stop,
    input  logic [1:0]                    cfg_width,
    input  logic [CNT_W-1:0]              cfg_rec_size,
    input  logic [CNT_W-1:0]              cfg_buf_size,
    input  logic                          cfg_hdr_en,
    input  logic                          cfg_ovf_ie,
    output logic [1:0]                    push_n,
    output logic [MAX_PUSH-1:0][WORD_W-1:0] push_dat,
    output logic                          irq_overflow,
    output logic                          msg_done,
    output logic                          buf_switch
);
    logic              open, ovf_seen;
    logic [CNT_W-1:0]  cnt, msg_cnt, rec_eff, cnt_cur, cnt_new, msg_cnt_inc;
    logic [WORD_W-1:0] acc, acc_cur, acc_new, masked, ts_cnt;
    logic [1:0]        lane, lane_cur;
    logic [2:0]        lane_sum;
    logic              opening, active, take, trunc, closing, word_full, ovf_cur;

    // Per-cycle framing decisions
    always_comb begin
        rec_eff  = (cfg_rec_size < CNT_W'(2)) ? CNT_W'(2) : cfg_rec_size;
        opening  = ~open & evt_start;
        active   = open | opening;
        cnt_cur  = opening ? '0 : cnt;
        acc_cur  = opening ? '0 : acc;
        lane_cur = opening ? 2'd0 : lane;
        ovf_cur  = opening ? 1'b0 : ovf_seen;
        take     = active & s_valid & (cnt_cur < rec_eff);
        trunc    = active & s_valid & ~(cnt_cur < rec_eff);
        closing  = active & evt_stop;
        cnt_new  = cnt_cur + CNT_W'(take);
    end

    // Lane packing of the incoming sample
    always_comb begin
        case (samp_w_e'(cfg_width))
            SW_BYTE: masked = {24'd0, s_data[7:0]};
            SW_HALF: masked = {16'd0, s_data[15:0]};
            default: masked = s_data;
        endcase
        acc_new   = take ? (acc_cur | (masked << {lane_cur, 3'b000})) : acc_cur;
        lane_sum  = {1'b0, lane_cur} + (take ? samp_bytes(cfg_width) : 3'd0);
        word_full = lane_sum[2];
    end

    // Ordered word slots: timestamp, data word, length word
    always_comb begin
        push_dat = '0;
        push_n   = 2'd0;
        if (opening && cfg_hdr_en) begin
            push_dat[push_n] = ts_cnt;
            push_n = push_n + 2'd1;
        end
        if (word_full || (closing && lane_sum != 3'd0)) begin
            push_dat[push_n] = acc_new;
            push_n = push_n + 2'd1;
        end
        if (closing && cfg_hdr_en) begin
            push_dat[push_n] = WORD_W'(cnt_new);
            push_n = push_n + 2'd1;
        end
    end

    assign msg_cnt_inc = msg_cnt + CNT_W'(1);

    // Record state, packing registers and pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open         <= 1'b0;
            ovf_seen     <= 1'b0;
            cnt          <= '0;
            acc          <= '0;
            lane         <= 2'd0;
            msg_cnt      <= '0;
            ts_cnt       <= '0;
            irq_overflow <= 1'b0;
            msg_done     <= 1'b0;
            buf_switch   <= 1'b0;
        end else begin
            open         <= active & ~closing;
            ovf_seen     <= ovf_cur | trunc;
            cnt          <= cnt_new;
            acc          <= (word_full || closing) ? '0 : acc_new;
            lane         <= (word_full || closing) ? 2'd0 : lane_sum[1:0];
            ts_cnt       <= ts_cnt + 32'd1;
            irq_overflow <= trunc & ~ovf_cur & cfg_ovf_ie;
            msg_done     <= closing;
            buf_switch   <= 1'b0;
            if (closing) begin
                if (msg_cnt_inc >= cfg_buf_size) begin
                    msg_cnt    <= '0;
                    buf_switch <= 1'b1;
                end else begin
                    msg_cnt <= msg_cnt_inc;
                end
            end
        end
    end

    a_r3_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_start && !open && !evt_stop) |=> open);
    a_r4_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (open && evt_stop) |=> !open);
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        open |-> (cnt <= rec_eff));
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_overflow |=> !irq_overflow);
    a_r10_switch_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        buf_switch |-> msg_done);
endmodule

// File: rtl/msg_packer.sv
// Top level of the framed sample packer: strobe edge detectors, record
// framer and output word queue. Assumes all inputs are synchronous to clk.
module msg_packer
    import msg_packer_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_valid,
    input  logic [31:0]      s_data,
    input  logic             start_pin,
    input  logic             stop_pin,
    input  logic             cfg_start_fall,
    input  logic             cfg_stop_fall,
    input  logic [1:0]       cfg_width,
    input  logic [CNT_W-1:0] cfg_rec_size,
    input  logic [CNT_W-1:0] cfg_buf_size,
    input  logic             cfg_hdr_en,
    input  logic             cfg_ovf_ie,
    output logic             o_valid,
    input  logic             o_ready,
    output logic [31:0]      o_data,
    output logic             irq_overflow,
    output logic             msg_done,
    output logic             buf_switch,
    output logic             drop_err
);
    localparam int NSTROBE = 2;

    logic [NSTROBE-1:0] pins, sels, evts;
    logic [1:0]         push_n;
    logic [MAX_PUSH-1:0][WORD_W-1:0] push_dat;

    assign pins = {stop_pin, start_pin};
    assign sels = {cfg_stop_fall, cfg_start_fall};

    // One event detector per strobe
    for (genvar g = 0; g < NSTROBE; g++) begin : g_strobe
        msg_edge_det u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (pins[g]),
            .fall_sel (sels[g]),
            .evt      (evts[g])
        );
    end

    msg_framer #(.CNT_W(CNT_W)) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .s_valid      (s_valid),
        .s_data       (s_data),
        .evt_start    (evts[0]),
        .evt_stop     (evts[1]),
        .cfg_width    (cfg_width),
        .cfg_rec_size (cfg_rec_size),
        .cfg_buf_size (cfg_buf_size),
        .cfg_hdr_en   (cfg_hdr_en),
        .cfg_ovf_ie   (cfg_ovf_ie),
        .push_n       (push_n),
        .push_dat     (push_dat),
        .irq_overflow (irq_overflow),
        .msg_done     (msg_done),
        .buf_switch   (buf_switch)
    );

    msg_word_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W), .NPUSH(MAX_PUSH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (push_n),
        .push_dat  (push_dat),
        .out_valid (o_valid),
        .out_ready (o_ready),
        .out_data  (o_data),
        .drop_err  (drop_err)
    );
endmodule

// File: tb/msg_packer_test.sv
module msg_packer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0;
    logic [31:0] s_data = '0;
    logic        start_pin = 1'b0, stop_pin = 1'b0;
    logic        cfg_start_fall = 1'b0, cfg_stop_fall = 1'b0;
    logic [1:0]  cfg_width = 2'd0;
    logic [15:0] cfg_rec_size = 16'd64, cfg_buf_size = 16'd1000;
    logic        cfg_hdr_en = 1'b0, cfg_ovf_ie = 1'b1;
    logic        o_valid, o_ready = 1'b1;
    logic [31:0] o_data;
    logic        irq_overflow, msg_done, buf_switch, drop_err;

    int n_chk = 0, n_err = 0;
    int cyc = 0, cap_n = 0, n_done = 0, n_sw = 0, n_irq = 0, cs = 0;
    logic [31:0] cap [0:255];

    always #5 clk = ~clk;

    msg_packer uut (.*);

    // Downstream monitor, samples like a flop at each rising edge
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (o_valid && o_ready && cap_n < 256) begin
                cap[cap_n] = o_data;
                cap_n = cap_n + 1;
            end
            if (msg_done)     n_done = n_done + 1;
            if (buf_switch)   n_sw = n_sw + 1;
            if (irq_overflow) n_irq = n_irq + 1;
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err = n_err + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_err = n_err + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sv(input int m, input int i);
        return {8'(m), 8'(i + 3), 8'(i * 7 + 1), 8'(i + m * 5)};
    endfunction

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One record: n offered samples, an idle cycle before every gap-th one, optional restart pulse
    task automatic send_msg(input int m, input int n, input int gap, input int restart);
        logic a_s, a_p;
        a_s = ~cfg_start_fall;
        a_p = ~cfg_stop_fall;
        for (int i = 0; i < n; i++) begin
            if (gap > 0 && i > 0 && i % gap == 0) begin
                @(negedge clk);
                s_valid = 1'b0; s_data = 32'hDEADBEEF;
                start_pin = ~a_s; stop_pin = ~a_p;
            end
            @(negedge clk);
            if (i == 0) cs = cyc;
            s_valid   = 1'b1;
            s_data    = sv(m, i);
            start_pin = (i == 0 || i == restart) ? a_s : ~a_s;
            stop_pin  = (i == n - 1) ? a_p : ~a_p;
        end
        @(negedge clk);
        s_valid = 1'b0; start_pin = ~a_s; stop_pin = ~a_p;
        repeat (12) @(negedge clk);
    endtask

    // Compare captured words against the packed first `ns` samples of record m
    task automatic expect_msg(input string req, input int m, input int ns, input int w, input int hdr);
        logic [7:0] by [0:255];
        int sb, nb, nw, off;
        logic [31:0] v, e;
        sb = (w == 0) ? 1 : (w == 1) ? 2 : 4;
        nb = 0;
        for (int s = 0; s < ns; s++) begin
            v = sv(m, s);
            for (int b = 0; b < sb; b++) begin
                by[nb] = v[8*b +: 8];
                nb = nb + 1;
            end
        end
        nw  = (nb + 3) / 4;
        off = hdr;
        chk({req, " word count"}, cap_n, nw + 2 * hdr);
        for (int j = 0; j < nw; j++) begin
            e = '0;
            for (int b = 0; b < 4; b++)
                if (4 * j + b < nb) e[8*b +: 8] = by[4*j + b];
            chk({req, " data word"}, cap[off + j], e);
        end
        if (hdr == 1) chk({req, " length word (R9)"}, cap[nw + 1], ns);
    endtask

    initial begin
        int d0, i0, ts_a, cs_a;
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 o_valid", o_valid, 0);
        chk("R1 pulses", {irq_overflow, msg_done, buf_switch}, 0);
        chk("R1 drop_err", drop_err, 0);

        // R3 R4 R5 R6 R10: sweep widths and lengths with rising strobes
        for (int w = 0; w < 3; w++) begin
            for (int n = 1; n <= 6; n++) begin
                cfg_width = 2'(w);
                cap_n = 0; d0 = n_done;
                send_msg(w * 10 + n, n, 0, -1);
                expect_msg("R5 R6 sweep", w * 10 + n, n, w, 0);
                chk("R10 one done per record", n_done - d0, 1);
            end
        end
        chk("R8 no irq without truncation", n_irq, 0);

        // R2: idle cycles with junk data are skipped
        cfg_width = 2'd1; cap_n = 0;
        send_msg(40, 5, 2, -1);
        expect_msg("R2 gaps", 40, 5, 1, 0);

        // R3 R4: falling-edge strobes; pins idle high first
        cfg_start_fall = 1'b1; cfg_stop_fall = 1'b1;
        @(negedge clk) start_pin = 1'b1; stop_pin = 1'b1;
        repeat (2) @(negedge clk);
        cfg_width = 2'd0; cap_n = 0; d0 = n_done;
        send_msg(41, 4, 0, -1);
        expect_msg("R3 R4 falling", 41, 4, 0, 0);
        chk("R4 falling done", n_done - d0, 1);
        cfg_width = 2'd3; cap_n = 0;
        send_msg(42, 3, 0, -1);
        expect_msg("R5 code3 is 32-bit", 42, 3, 2, 0);
        cfg_start_fall = 1'b0; cfg_stop_fall = 1'b0;
        @(negedge clk) start_pin = 1'b0; stop_pin = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3 no event on config change", n_done - d0, 2);

        // R3: second start inside an open record is ignored
        cfg_width = 2'd0; cap_n = 0; d0 = n_done;
        send_msg(43, 6, 0, 3);
        expect_msg("R3 restart ignored", 43, 6, 0, 0);
        chk("R3 single record", n_done - d0, 1);

        // R4: stop pulse with no open record
        cap_n = 0; d0 = n_done;
        @(negedge clk) stop_pin = 1'b1; s_valid = 1'b1; s_data = 32'h12345678;
        @(negedge clk) stop_pin = 1'b0; s_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk("R4 stray stop no done", n_done - d0, 0);
        chk("R4 stray stop no words", cap_n, 0);

        // R7 R8: truncation with and without interrupt
        cfg_width = 2'd2; cfg_rec_size = 16'd4; cap_n = 0; i0 = n_irq;
        send_msg(44, 7, 0, -1);
        expect_msg("R7 truncate", 44, 4, 2, 0);
        chk("R8 one irq", n_irq - i0, 1);
        cfg_ovf_ie = 1'b0; cap_n = 0; i0 = n_irq;
        send_msg(45, 7, 0, -1);
        expect_msg("R7 truncate masked", 45, 4, 2, 0);
        chk("R8 irq masked", n_irq - i0, 0);
        cfg_ovf_ie = 1'b1; cfg_rec_size = 16'd0; cap_n = 0;
        send_msg(46, 5, 0, -1);
        expect_msg("R7 size0 acts as 2", 46, 2, 2, 0);
        cfg_rec_size = 16'd1; cap_n = 0;
        send_msg(47, 5, 0, -1);
        expect_msg("R7 size1 acts as 2", 47, 2, 2, 0);

        // R9: header words
        cfg_rec_size = 16'd64; cfg_hdr_en = 1'b1; cfg_width = 2'd0; cap_n = 0;
        send_msg(48, 5, 0, -1);
        expect_msg("R9 header 8-bit", 48, 5, 0, 1);
        ts_a = cap[0]; cs_a = cs;
        cfg_width = 2'd1; cap_n = 0;
        send_msg(49, 3, 0, -1);
        expect_msg("R9 header 16-bit", 49, 3, 1, 1);
        chk("R9 timestamp delta", cap[0] - ts_a, cs - cs_a);
        cfg_width = 2'd2; cfg_rec_size = 16'd3; cap_n = 0;
        send_msg(50, 6, 0, -1);
        expect_msg("R9 header truncated", 50, 3, 2, 1);
        cfg_hdr_en = 1'b0; cfg_rec_size = 16'd64;

        // R10: buffer switch every third record after reset, then every record for 0
        do_reset();
        cfg_buf_size = 16'd3; d0 = n_done; i0 = n_sw;
        for (int k = 0; k < 7; k++) send_msg(60 + k, 2, 0, -1);
        chk("R10 done count", n_done - d0, 7);
        chk("R10 switch count", n_sw - i0, 2);
        cfg_buf_size = 16'd0; i0 = n_sw;
        send_msg(70, 2, 0, -1);
        send_msg(71, 2, 0, -1);
        chk("R10 size0 switches every record", n_sw - i0, 2);

        // R11: stall then release, order kept
        cfg_width = 2'd2; o_ready = 1'b0; cap_n = 0;
        send_msg(72, 5, 0, -1);
        chk("R11 nothing taken while stalled", cap_n, 0);
        chk("R11 valid while stalled", o_valid, 1);
        @(negedge clk) o_ready = 1'b1;
        repeat (10) @(negedge clk);
        expect_msg("R11 released", 72, 5, 2, 0);

        // R12: queue overflow drops words, flag sticky
        chk("R12 flag clear before", drop_err, 0);
        o_ready = 1'b0; cap_n = 0;
        send_msg(73, 12, 0, -1);
        chk("R12 flag set", drop_err, 1);
        @(negedge clk) o_ready = 1'b1;
        repeat (12) @(negedge clk);
        expect_msg("R12 first words kept", 73, 8, 2, 0);
        chk("R12 flag sticky", drop_err, 1);
        do_reset();
        @(negedge clk);
        chk("R1 R12 flag cleared by reset", drop_err, 0);

        summary();
    end
endmodule